// File: doc/BRIEF.md
# Single-Digit Decimal Up/Down Counter

This block keeps one decimal digit, 0 through 9, and shows it on a seven-segment display. Two push-buttons step the digit. One raises it and the other lowers it. Each button moves the digit once per press: the block sets a stored flag when it first sees a button held and clears that flag only when it sees the button released. While a load strobe is high, the digit is taken from a four-bit switch value instead.

All button, strobe and switch inputs pass through a two-flop synchronizer before use. Every output is registered. The outputs are:
- an active-low segment pattern for the present digit,
- an active-low digit enable that lights only the rightmost display position,
- four LEDs that echo the switch value.

Top module: `updown_digit_counter`

## Requirements
- R1: While reset is high on a clock edge, the count becomes 0, both pressed flags clear, the segment output shows 0 (8'hC0) and the LED output is 0.
- R2: The count never leaves the range 0 to 9.
- R3: While the synchronized load strobe is 1, the count takes the synchronized load value. A load overrides any button press in the same cycle, and a press already absorbed during the load does not step the count later.
- R4: A load value above 9 is clamped, so the count becomes 9.
- R5: A new press on btn_i bit 0 (UP) increments the count exactly once. Holding the button does not count again, and releasing it does not count.
- R6: A new press on btn_i bit 1 (DOWN) decrements the count exactly once per press, under the same press/release rule.
- R7: Counting up from 9 gives 0, and counting down from 0 gives 9.
- R8: New UP and DOWN presses seen in the same cycle cancel, and the count is unchanged.
- R9: led_o equals load_val_i as it was one clock earlier, whatever the strobe and the buttons do.
- R10: dig_en_o is 4'b1110 outside reset: active low, with bit 0 the rightmost digit.
- R11: seg_o is active low, with bit 0 = segment a through bit 6 = segment g, and bit 7 = decimal point held at 1 (off). The lit segments are the usual decimal glyphs: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_val_i | input | 4 | Switch value to load, also echoed on the LEDs |
| load_i | input | 1 | Load strobe, level-sensitive |
| btn_i | input | 2 | Buttons: bit 0 UP, bit 1 DOWN, 1 = held |
| seg_o | output | 8 | Active-low segment pattern, bit 7 decimal point |
| dig_en_o | output | 4 | Active-low digit enable, bit 0 rightmost |
| led_o | output | 4 | LEDs mirroring the load value |

## Verification
The cycle-level properties are checked on every clock edge:
- the range limit,
- the load and clamp result,
- single steps with wrap,
- cancellation of simultaneous presses,
- that a detected press cannot repeat on the next cycle,
- the LED echo, the fixed digit enable and the dark decimal point.

Only the bench's scenarios show the behaviours that span many cycles. These include a long hold counting just once and a release not counting. They also include a press absorbed under a load staying ignored after the strobe drops, and every digit's glyph shape on the segment pins.

// File: rtl/updown_digit_pkg.sv
package updown_digit_pkg;

  // Active-high glyph, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [6:0] glyph_on(input int unsigned d);
    logic [6:0] g;
    case (d)
      0: g = 7'b0111111;
      1: g = 7'b0000110;
      2: g = 7'b1011011;
      3: g = 7'b1001111;
      4: g = 7'b1100110;
      5: g = 7'b1101101;
      6: g = 7'b1111101;
      7: g = 7'b0000111;
      8: g = 7'b1111111;
      9: g = 7'b1101111;
      default: g = 7'b0000000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/updown_bit_sync.sv
module updown_bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/updown_press_edge.sv
module updown_press_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] btn_i,
  output logic [N-1:0] new_o
);
  for (genvar i = 0; i < N; i++) begin : g_btn
    logic held_q;
    // flag set when the press is seen, cleared once release is seen
    always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= btn_i[i];
    end
    assign new_o[i] = btn_i[i] & ~held_q;
  end
endmodule

// File: rtl/updown_digit_state.sv
module updown_digit_state #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load_i)             count_d = (val_i > TOP) ? TOP : val_i;
    else if (up_i && !dn_i) count_d = (count_q >= TOP) ? '0 : count_q + 1'b1;
    else if (dn_i && !up_i) count_d = (count_q == '0) ? TOP : count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/updown_seg_drive.sv
module updown_seg_drive
  import updown_digit_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEG_W = 8,
  parameter int EN_W  = 4,
  parameter int LED_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     count_i,
  input  logic [LED_W-1:0] led_val_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [EN_W-1:0]  en_o,
  output logic [LED_W-1:0] led_o
);
  localparam logic [EN_W-1:0] EN_RIGHT = ~EN_W'(1);

  logic [SEG_W-1:0] lit_w, lit_zero;

  assign lit_w    = SEG_W'(glyph_on(32'(count_i)));
  assign lit_zero = SEG_W'(glyph_on(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o <= ~lit_zero;
      en_o  <= EN_RIGHT;
      led_o <= '0;
    end else begin
      seg_o <= ~lit_w;
      en_o  <= EN_RIGHT;
      led_o <= led_val_i;
    end
  end
endmodule

// File: rtl/updown_digit_counter.sv
module updown_digit_counter #(
  parameter int VAL_W       = 4,
  parameter int BTN_N       = 2,
  parameter int SEG_W       = 8,
  parameter int EN_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DIGIT_MAX   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] load_val_i,
  input  logic             load_i,
  input  logic [BTN_N-1:0] btn_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [EN_W-1:0]  dig_en_o,
  output logic [VAL_W-1:0] led_o
);
  localparam int SW = VAL_W + BTN_N + 1;

  logic [SW-1:0]    sync_w;
  logic [VAL_W-1:0] val_s;
  logic [BTN_N-1:0] btn_s, press_new;
  logic             load_s;
  logic [VAL_W-1:0] count_q;

  updown_bit_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({load_i, btn_i, load_val_i}),
    .q_o(sync_w)
  );

  assign {load_s, btn_s, val_s} = sync_w;

  updown_press_edge #(.N(BTN_N)) u_press (
    .clk(clk), .rst(rst), .btn_i(btn_s), .new_o(press_new)
  );

  updown_digit_state #(.W(VAL_W), .MAX(DIGIT_MAX)) u_state (
    .clk(clk), .rst(rst),
    .load_i(load_s), .val_i(val_s),
    .up_i(press_new[0]), .dn_i(press_new[1]),
    .count_o(count_q)
  );

  updown_seg_drive #(.W(VAL_W), .SEG_W(SEG_W), .EN_W(EN_W), .LED_W(VAL_W)) u_drive (
    .clk(clk), .rst(rst),
    .count_i(count_q), .led_val_i(load_val_i),
    .seg_o(seg_o), .en_o(dig_en_o), .led_o(led_o)
  );
endmodule

// File: rtl/updown_digit_counter_chk.sv
module updown_digit_counter_chk #(
  parameter int W     = 4,
  parameter int MAX   = 9,
  parameter int SEG_W = 8,
  parameter int EN_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     count,
  input logic             up_new,
  input logic             dn_new,
  input logic             load_s,
  input logic [W-1:0]     val_s,
  input logic [SEG_W-1:0] seg,
  input logic [EN_W-1:0]  en,
  input logic [W-1:0]     led,
  input logic [W-1:0]     val_raw
);
  localparam logic [W-1:0] TOP = W'(MAX);

  p_range_r2: assert property (@(posedge clk) disable iff (rst) count <= TOP);

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_s && $past(!rst) |=> count == (($past(val_s) > TOP) ? TOP : $past(val_s)));

  p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
    !load_s && up_new && !dn_new |=>
      count == (($past(count) == TOP) ? '0 : $past(count) + 1'b1));

  p_up_once_r5: assert property (@(posedge clk) disable iff (rst) up_new |=> !up_new);

  p_dn_step_r6: assert property (@(posedge clk) disable iff (rst)
    !load_s && dn_new && !up_new |=>
      count == (($past(count) == '0) ? TOP : $past(count) - 1'b1));

  p_dn_once_r6: assert property (@(posedge clk) disable iff (rst) dn_new |=> !dn_new);

  p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    !load_s && (up_new == dn_new) |=> $stable(count));

  p_led_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> led == $past(val_raw));

  p_enable_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> en == ~EN_W'(1));

  p_dp_off_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> seg[SEG_W-1]);
endmodule

bind updown_digit_counter updown_digit_counter_chk #(
  .W(VAL_W), .MAX(DIGIT_MAX), .SEG_W(SEG_W), .EN_W(EN_W)
) u_chk (
  .clk(clk), .rst(rst), .count(count_q),
  .up_new(press_new[0]), .dn_new(press_new[1]),
  .load_s(load_s), .val_s(val_s),
  .seg(seg_o), .en(dig_en_o), .led(led_o), .val_raw(load_val_i)
);

// File: tb/updown_digit_counter_tb.sv
`timescale 1ns/1ps
module updown_digit_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] load_val = 4'd0;
  logic       load = 1'b0;
  logic [1:0] btn = 2'b00;
  logic [7:0] seg;
  logic [3:0] en;
  logic [3:0] led;

  int errs = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] seg;
    logic [3:0] en;
    logic [3:0] led;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  updown_digit_counter u_dut (
    .clk(clk), .rst(rst), .load_val_i(load_val), .load_i(load),
    .btn_i(btn), .seg_o(seg), .dig_en_o(en), .led_o(led)
  );

  function automatic logic [7:0] exp_seg(input int d);
    logic [6:0] on;
    case (d)
      0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F; 4: on = 7'h66;
      5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07; 8: on = 7'h7F; 9: on = 7'h6F;
      default: on = 7'h00;
    endcase
    return {1'b1, ~on};
  endfunction

  // monitor: pops expectations and compares with the outputs
  always @(negedge clk) begin : mon
    item_t it;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      checks++;
      if (seg !== it.seg) begin
        errs++;
        $display("FAIL %s seg actual=%h expected=%h", it.tag, seg, it.seg);
      end
      checks++;
      if (en !== it.en) begin
        errs++;
        $display("FAIL %s en actual=%b expected=%b", it.tag, en, it.en);
      end
      checks++;
      if (led !== it.led) begin
        errs++;
        $display("FAIL %s led actual=%h expected=%h", it.tag, led, it.led);
      end
    end
  end

  task automatic settle(input int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input logic [3:0] exp_led = load_val,
                             input logic [3:0] exp_en = 4'b1110);
    sbq.push_back('{exp_seg(exp_cnt), exp_en, exp_led, tag});
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic press(input logic [1:0] b, input int hold);
    btn = b;
    settle(hold);
    btn = 2'b00;
    settle();
  endtask

  task automatic do_load(input logic [3:0] v);
    load_val = v;
    load = 1'b1;
    settle();
    load = 1'b0;
    settle();
  endtask

  initial begin
    settle(2);
    load_val = 4'd5;
    settle(2);
    exp_cnt = 0;
    expect_item("R1 in reset", 4'd0);
    rst = 1'b0;
    settle();
    expect_item("R1 after reset");
    expect_item("R10 enable after reset");

    for (int k = 0; k < 3; k++) begin
      press(2'b01, 4);
      exp_cnt++;
      expect_item("R5 up press");
    end
    press(2'b01, 40);
    exp_cnt++;
    expect_item("R5 long hold counts once");

    do_load(4'd7); exp_cnt = 7;
    expect_item("R3 load 7");
    do_load(4'd12); exp_cnt = 9;
    expect_item("R4 clamp 12");
    do_load(4'd15); exp_cnt = 9;
    expect_item("R4 clamp 15");
    expect_item("R2 range after clamp");

    press(2'b01, 4); exp_cnt = 0;
    expect_item("R7 wrap up 9 to 0");
    press(2'b10, 4); exp_cnt = 9;
    expect_item("R7 wrap down 0 to 9");
    press(2'b10, 4); exp_cnt = 8;
    expect_item("R6 down press");
    press(2'b10, 30); exp_cnt = 7;
    expect_item("R6 held down once");
    press(2'b11, 6);
    expect_item("R8 both cancel");

    load_val = 4'd4; load = 1'b1; btn = 2'b01;
    settle(); exp_cnt = 4;
    expect_item("R3 load beats up");
    load = 1'b0;
    settle();
    expect_item("R3 held press absorbed by load");
    btn = 2'b00;
    settle();
    expect_item("R5 release does not count");

    load_val = 4'd6;
    settle(2);
    expect_item("R9 led mirrors without load");
    load_val = 4'd11;
    settle(2);
    expect_item("R9 led mirrors 11");

    for (int d = 0; d < 10; d++) begin
      do_load(4'(d)); exp_cnt = d;
      expect_item("R11 glyph");
    end

    rst = 1'b1;
    settle(2);
    exp_cnt = 0;
    expect_item("R1 reset mid-run", 4'd0);
    rst = 1'b0;
    settle();
    expect_item("R1 count zero after reset");
    press(2'b10, 4); exp_cnt = 9;
    expect_item("R7 down from reset zero");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule